// File: doc/BRIEF.md
# Guarded Multi-Bus Move Interconnect

This block is the programmable transport network of a processor that is driven by data moves. Each instruction carries one move slot per transport bus. A slot names the source output port that drives the bus, the destination input port that takes the bus value, and an optional guard condition. The function units, register files and instruction decoder sit outside the block. They present their output values on a flat source-data input and take write enables and data from flat destination outputs.

Every bus is evaluated in parallel and without registers. The value of a bus is the selected source word. A slot that is valid and whose guard holds produces a write strobe and data on its destination port in the same cycle. A guard that fails squashes the write. When two live moves aim at the same destination, the lower-numbered bus is the one that writes, and a conflict flag is raised.

Top module: `move_fabric`

## Requirements
- R1: Each bus output `bus_data_o` slice b always equals the `src_data_i` word at the index in that bus's source field, whether or not the slot is valid or its guard holds.
- R2: A valid slot with guard code 0 (unguarded) always writes: the named destination's enable is 1 and its data equals that bus's value, combinationally.
- R3: The guard codes are 1 (write when `cond_i[0]`=1), 2 (write when `cond_i[1]`=1) and 3 (write when `cond_i[0]`=0). A failing guard squashes the write and leaves that destination without a write from that bus.
- R4: A slot with its valid bit at 0 produces no write, whatever its guard and fields hold. With all slots invalid, every enable is 0 and every destination word is 0.
- R5: A destination that no live move targets has its enable at 0 and its data at 0.
- R6: Live moves on different buses to different destinations all take effect in the same evaluation.
- R7: When two or more live moves target one destination, the lowest-numbered of those buses supplies the data and `conflict_o` is 1. `conflict_o` is 0 when no destination has more than one live move. Squashed and invalid moves never cause a conflict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_valid_i | input | NBUS | Valid bit per bus slot |
| slot_src_i | input | NBUS*SW | Source port index per bus, bus b at bits [b*SW +: SW] |
| slot_dst_i | input | NBUS*DW | Destination port index per bus, bus b at bits [b*DW +: DW] |
| slot_guard_i | input | NBUS*2 | Guard code per bus, bus b at bits [b*2 +: 2] |
| cond_i | input | 2 | Guard condition bits g0 (bit 0) and g1 (bit 1) |
| src_data_i | input | NSRC*W | Source output words, port p at bits [p*W +: W] |
| bus_data_o | output | NBUS*W | Value carried by each bus |
| dst_we_o | output | NDST | Write enable per destination port |
| dst_data_o | output | NDST*W | Data per destination port, zero when not written |
| conflict_o | output | 1 | Two or more live moves targeted one destination |

With the defaults NBUS=3, NSRC=8, NDST=8, W=32: SW=3 and DW=3.

## Verification
The assertions assume that the slot fields hold index values below the port counts. With the default sizes every 3-bit code is a real port, and the bench drives every value. They also take the inputs as settled when the combinational checks run. The bench changes inputs only between clock edges and waits before it samples. The sweeps cover every destination triple under every valid pattern, every guard and condition combination, and shifted source selections. This includes the collisions on which R7 depends.

// File: rtl/move_fabric.sv
module move_fabric #(
  parameter int NBUS = 3,
  parameter int NSRC = 8,
  parameter int NDST = 8,
  parameter int W    = 32,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DW  = (NDST > 1) ? $clog2(NDST) : 1
) (
  input  logic [NBUS-1:0]    slot_valid_i,
  input  logic [NBUS*SW-1:0] slot_src_i,
  input  logic [NBUS*DW-1:0] slot_dst_i,
  input  logic [NBUS*2-1:0]  slot_guard_i,
  input  logic [1:0]         cond_i,
  input  logic [NSRC*W-1:0]  src_data_i,
  output logic [NBUS*W-1:0]  bus_data_o,
  output logic [NDST-1:0]    dst_we_o,
  output logic [NDST*W-1:0]  dst_data_o,
  output logic               conflict_o
);

  logic [W-1:0]    bus [NBUS];
  logic [NBUS-1:0] live;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic [SW-1:0] sel;
    logic [1:0]    gcode;
    logic          pass;
    assign sel   = slot_src_i[b*SW +: SW];
    assign gcode = slot_guard_i[b*2 +: 2];

    always_comb begin
      bus[b] = '0;
      for (int p = 0; p < NSRC; p++)
        if (sel == SW'(p)) bus[b] = src_data_i[p*W +: W];
    end

    always_comb begin
      case (gcode)
        2'd0:    pass = 1'b1;
        2'd1:    pass = cond_i[0];
        2'd2:    pass = cond_i[1];
        default: pass = ~cond_i[0];
      endcase
    end

    assign live[b] = slot_valid_i[b] & pass;
    assign bus_data_o[b*W +: W] = bus[b];
  end

  always_comb begin
    dst_we_o   = '0;
    dst_data_o = '0;
    conflict_o = 1'b0;
    for (int d = 0; d < NDST; d++) begin
      int hits;
      hits = 0;
      for (int b = NBUS - 1; b >= 0; b--) begin
        if (live[b] && slot_dst_i[b*DW +: DW] == DW'(d)) begin
          dst_we_o[d]            = 1'b1;
          dst_data_o[d*W +: W]   = bus[b];
          hits++;
        end
      end
      if (hits > 1) conflict_o = 1'b1;
    end
  end

  always_comb begin
    for (int b = 0; b < NBUS; b++)
      for (int p = 0; p < NSRC; p++)
        if (slot_src_i[b*SW +: SW] == SW'(p))
          a_r1_bus_follows_source: assert (bus_data_o[b*W +: W] == src_data_i[p*W +: W]);
    for (int b = 0; b < NBUS; b++)
      if (slot_valid_i[b] && slot_guard_i[b*2 +: 2] == 2'd0)
        a_r2_unguarded_writes: assert (dst_we_o[slot_dst_i[b*DW +: DW]]);
    a_r4_writes_need_valid: assert ($countones(dst_we_o) <= $countones(slot_valid_i));
    for (int d = 0; d < NDST; d++)
      if (!dst_we_o[d])
        a_r5_idle_port_zero: assert (dst_data_o[d*W +: W] == '0);
    if (conflict_o)
      a_r7_conflict_merges: assert ($countones(dst_we_o) < $countones(slot_valid_i));
  end

endmodule

// File: tb/move_fabric_test.sv
module move_fabric_test;
  localparam int NB = 3, NS = 8, ND = 8, W = 32, SW = 3, DW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [NB-1:0]    valid;
  logic [NB*SW-1:0] src;
  logic [NB*DW-1:0] dst;
  logic [NB*2-1:0]  guard;
  logic [1:0]       cond;
  logic [NS*W-1:0]  sdata;
  logic [NB*W-1:0]  busd;
  logic [ND-1:0]    we;
  logic [ND*W-1:0]  ddata;
  logic             conflict;

  move_fabric #(.NBUS(NB), .NSRC(NS), .NDST(ND), .W(W)) uut (
    .slot_valid_i(valid), .slot_src_i(src), .slot_dst_i(dst),
    .slot_guard_i(guard), .cond_i(cond), .src_data_i(sdata),
    .bus_data_o(busd), .dst_we_o(we), .dst_data_o(ddata), .conflict_o(conflict));

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit guard_ok(input logic [1:0] g, input logic [1:0] c);
    return (g == 0) || (g == 1 && c[0]) || (g == 2 && c[1]) || (g == 3 && !c[0]);
  endfunction

  task automatic apply_and_check(input string tag);
    logic [ND-1:0] ewe;
    logic [W-1:0]  edat [ND];
    int            cnt [ND];
    logic          econf;
    @(negedge clk);
    ewe = '0; econf = 0;
    for (int d = 0; d < ND; d++) begin edat[d] = '0; cnt[d] = 0; end
    for (int b = 0; b < NB; b++) begin
      int s = int'(src[b*SW +: SW]);
      int d = int'(dst[b*DW +: DW]);
      chk("R1 bus value", busd[b*W +: W], sdata[s*W +: W]);
      if (valid[b] && guard_ok(guard[b*2 +: 2], cond)) begin
        if (cnt[d] == 0) begin ewe[d] = 1; edat[d] = sdata[s*W +: W]; end
        else econf = 1;
        cnt[d]++;
      end
    end
    for (int d = 0; d < ND; d++) begin
      chk({tag, " R2/R3/R4/R6 enable"}, W'(we[d]), W'(ewe[d]));
      chk({tag, " R5/R7 data"}, ddata[d*W +: W], edat[d]);
    end
    chk({tag, " R7 conflict"}, W'(conflict), W'(econf));
  endtask

  task automatic load_sources(input int salt);
    for (int p = 0; p < NS; p++) sdata[p*W +: W] = 32'h9E37_79B9 * (p + 1) + 32'(salt * 7919);
  endtask

  initial begin
    valid = '0; src = '0; dst = '0; guard = '0; cond = '0;
    load_sources(0);
    @(negedge clk);
    // R4: all slots invalid, nothing written
    chk("R4 idle enables", W'(we), '0);
    chk("R4 idle data low", ddata[W-1:0], '0);
    chk("R7 idle conflict", W'(conflict), '0);

    // R2 / R6 directed: three unguarded moves in parallel
    valid = 3'b111; guard = '0;
    src = {3'd5, 3'd2, 3'd7}; dst = {3'd6, 3'd0, 3'd3};
    @(negedge clk);
    chk("R6 bus0 to port3", ddata[3*W +: W], sdata[7*W +: W]);
    chk("R6 bus1 to port0", ddata[0*W +: W], sdata[2*W +: W]);
    chk("R6 bus2 to port6", ddata[6*W +: W], sdata[5*W +: W]);
    // R7 directed: buses 1 and 2 both aim at port 4, bus 1 wins
    dst = {3'd4, 3'd4, 3'd1};
    @(negedge clk);
    chk("R7 lower bus wins", ddata[4*W +: W], sdata[2*W +: W]);
    chk("R7 flag raised", W'(conflict), 32'd1);
    // R3 directed: bus1 guarded on g1 false squashes it, bus2 then writes alone
    guard = {2'd0, 2'd2, 2'd0}; cond = 2'b01;
    @(negedge clk);
    chk("R3 squashed bus yields", ddata[4*W +: W], sdata[5*W +: W]);
    chk("R7 no conflict when squashed", W'(conflict), 32'd0);

    // Sweep A: all destination triples, valid patterns, conditions, rotated guards
    for (int dd = 0; dd < 512; dd++)
      for (int v = 0; v < 8; v++)
        for (int c = 0; c < 4; c++) begin
          valid = 3'(v); cond = 2'(c);
          dst = 9'(dd);
          for (int b = 0; b < NB; b++) begin
            guard[b*2 +: 2] = 2'((dd >> (3*b)) + b + v);
            src[b*SW +: SW] = 3'(dd * 3 + b + c);
          end
          load_sources(dd + c);
          apply_and_check("sweepA");
        end

    // Sweep B: distinct destinations, every guard triple and condition
    dst = {3'd7, 3'd2, 3'd5}; src = {3'd1, 3'd6, 3'd3}; valid = 3'b111;
    for (int g = 0; g < 64; g++)
      for (int c = 0; c < 4; c++) begin
        guard = 6'(g); cond = 2'(c);
        apply_and_check("sweepB R3");
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule